// File: doc/BRIEF.md
# Protected Page Translation Buffer

This block is a small fully associative translation buffer that turns an effective page number into a physical page number and, in the same lookup, decides whether the access is allowed. Each lookup carries a page number, an access kind (instruction fetch, data load or data store) and the current process identifier. One clock later it returns either the physical page number or exactly one exception code: no matching entry, fetch denied, or data write denied.

Two separate enables, one for instruction fetches and one for data accesses, turn translation on. When the enable for an access kind is clear, that access passes through untranslated and raises no exception. Software loads and clears entries through an indexed write port, and a single global invalidate input clears every valid bit at once. The hardware never changes the valid or write-enable bits of an entry by itself. Software can therefore use a cleared valid bit to record first use of a page and a cleared write-enable bit to record its first modification.

Top module: `tlb_guard`

## Requirements
- R1: After reset, `rsp_vld` is 0 and every entry is invalid, so any translated lookup reports a miss.
- R2: `rsp_vld` is `req_vld` delayed by exactly one clock. While `rsp_vld` is 0, `rsp_exc` is 0 and `rsp_ppn` is 0.
- R3: A fetch (`req_kind`=0) with `xlat_ins_en`=0, or a load (1) or store (2) with `xlat_dat_en`=0, returns `rsp_exc`=0 (none) and `rsp_ppn` equal to `req_epn`, zero-extended.
- R4: An entry matches only when its valid bit is 1, its stored page equals `req_epn`, and its 8-bit tag is zero or equal to `req_pid`. A translated lookup with no matching entry returns `rsp_exc`=1 (miss) and `rsp_ppn`=0.
- R5: A store that hits an entry whose write-enable bit is 0 returns `rsp_exc`=3 (data denied) and `rsp_ppn`=0. A load that hits the same entry returns `rsp_exc`=0 and the entry's physical page.
- R6: A fetch ignores the write-enable bit. A fetch that hits an entry whose execute-enable bit is 0 returns `rsp_exc`=2 (fetch denied) and `rsp_ppn`=0.
- R7: When several entries match, the lowest-numbered one alone sets the physical page and the permissions. A miss takes priority over every permission exception.
- R8: A write through the entry port takes effect for lookups issued on the following cycle. A lookup issued in the same cycle as the write sees the old contents.
- R9: With `inv_all` high, every valid bit is 0 for lookups on the next cycle. This includes an entry written in the same cycle.
- R10: Lookups never modify entries. A repeated miss stays a miss, and a repeated denied store stays denied until software rewrites the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_ins_en | input | 1 | Translate and check instruction fetches |
| xlat_dat_en | input | 1 | Translate and check loads and stores |
| req_vld | input | 1 | Lookup strobe |
| req_epn | input | 20 | Effective page number |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store (3 treated as load) |
| req_pid | input | 8 | Current process identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_epn | input | 20 | Effective page for the entry |
| wr_rpn | input | 20 | Physical page for the entry |
| wr_tid | input | 8 | Process tag, 0 matches any process |
| wr_valid | input | 1 | Valid (reference) bit |
| wr_wren | input | 1 | Write-enable (change) bit |
| wr_exen | input | 1 | Execute-enable bit |
| inv_all | input | 1 | Clear all valid bits |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_ppn | output | 20 | Physical page number, 0 on an exception |
| rsp_exc | output | 2 | 0 none, 1 miss, 2 fetch denied, 3 data denied |

## Verification
The assertions assume that `req_kind` never carries the reserved code 3 and that each input is stable around the rising clock edge. The exception-origin properties also assume that a response relates only to the request of the previous cycle, with no gap. The stimulus draws `req_kind` only from 0 to 2 and changes every input at the falling edge. It takes page numbers and process tags from small pools, so that multiple matches, tag mismatches and invalidated entries come up often within these limits.

// File: rtl/tlb_guard_pkg.sv
package tlb_guard_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      EXC_NONE  = 2'd0,
      EXC_MISS  = 2'd1,
      EXC_FETCH = 2'd2,
      EXC_DATA  = 2'd3
   } exc_code_e;
endpackage

// File: rtl/tlb_guard_store.sv
// Entry storage: indexed write port and single-cycle global invalidate.
module tlb_guard_store #(
   parameter int ENTRIES = 16,
   parameter int EPN_W   = 20,
   parameter int RPN_W   = 20,
   parameter int TID_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [EPN_W-1:0]              wr_epn,
   input  logic [RPN_W-1:0]              wr_rpn,
   input  logic [TID_W-1:0]              wr_tid,
   input  logic                          wr_valid,
   input  logic                          wr_wren,
   input  logic                          wr_exen,
   input  logic                          inv_all,
   output logic [ENTRIES-1:0]            ent_vld,
   output logic [ENTRIES-1:0]            ent_wr,
   output logic [ENTRIES-1:0]            ent_ex,
   output logic [ENTRIES-1:0][EPN_W-1:0] ent_epn,
   output logic [ENTRIES-1:0][RPN_W-1:0] ent_rpn,
   output logic [ENTRIES-1:0][TID_W-1:0] ent_tid
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vld[g] <= 1'b0;
            ent_wr[g]  <= 1'b0;
            ent_ex[g]  <= 1'b0;
            ent_epn[g] <= '0;
            ent_rpn[g] <= '0;
            ent_tid[g] <= '0;
         end else begin
            if (sel) begin
               ent_vld[g] <= wr_valid;
               ent_wr[g]  <= wr_wren;
               ent_ex[g]  <= wr_exen;
               ent_epn[g] <= wr_epn;
               ent_rpn[g] <= wr_rpn;
               ent_tid[g] <= wr_tid;
            end
            // invalidate wins over a write in the same cycle
            if (inv_all) ent_vld[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tlb_guard_match.sv
// Parallel compare of every entry against the lookup key.
module tlb_guard_match #(
   parameter int ENTRIES = 16,
   parameter int EPN_W   = 20,
   parameter int TID_W   = 8
) (
   input  logic [ENTRIES-1:0]            ent_vld,
   input  logic [ENTRIES-1:0][EPN_W-1:0] ent_epn,
   input  logic [ENTRIES-1:0][TID_W-1:0] ent_tid,
   input  logic [EPN_W-1:0]              key_epn,
   input  logic [TID_W-1:0]              key_pid,
   output logic [ENTRIES-1:0]            hit
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic tag_ok;
      assign tag_ok = (ent_tid[g] == '0) || (ent_tid[g] == key_pid);
      assign hit[g] = ent_vld[g] && (ent_epn[g] == key_epn) && tag_ok;
   end
endmodule

// File: rtl/tlb_guard_pick.sv
// Lowest-index priority select of the hit vector.
module tlb_guard_pick #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] hit,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit[i]) idx = IDX_W'(i);
      end
   end
   assign any = |hit;
endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
   import tlb_guard_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int EPN_W   = 20,
   parameter int RPN_W   = 20,
   parameter int TID_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlat_ins_en,
   input  logic             xlat_dat_en,
   input  logic             req_vld,
   input  logic [EPN_W-1:0] req_epn,
   input  logic [1:0]       req_kind,
   input  logic [TID_W-1:0] req_pid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [EPN_W-1:0] wr_epn,
   input  logic [RPN_W-1:0] wr_rpn,
   input  logic [TID_W-1:0] wr_tid,
   input  logic             wr_valid,
   input  logic             wr_wren,
   input  logic             wr_exen,
   input  logic             inv_all,
   output logic             rsp_vld,
   output logic [RPN_W-1:0] rsp_ppn,
   output logic [1:0]       rsp_exc
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_guard: ENTRIES must be at least 2");
   end
   if (RPN_W < EPN_W) begin : g_bad_width
      $error("tlb_guard: RPN_W must not be narrower than EPN_W");
   end
   if (TID_W < 1) begin : g_bad_tid
      $error("tlb_guard: TID_W must be positive");
   end

   logic [ENTRIES-1:0]            ent_vld, ent_wr, ent_ex, hit;
   logic [ENTRIES-1:0][EPN_W-1:0] ent_epn;
   logic [ENTRIES-1:0][RPN_W-1:0] ent_rpn;
   logic [ENTRIES-1:0][TID_W-1:0] ent_tid;
   logic                          any_hit;
   logic [IDX_W-1:0]              hit_idx;

   tlb_guard_store #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .RPN_W(RPN_W), .TID_W(TID_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_epn(wr_epn),
      .wr_rpn(wr_rpn), .wr_tid(wr_tid), .wr_valid(wr_valid), .wr_wren(wr_wren),
      .wr_exen(wr_exen), .inv_all(inv_all), .ent_vld(ent_vld), .ent_wr(ent_wr),
      .ent_ex(ent_ex), .ent_epn(ent_epn), .ent_rpn(ent_rpn), .ent_tid(ent_tid)
   );

   tlb_guard_match #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .TID_W(TID_W)) u_match (
      .ent_vld(ent_vld), .ent_epn(ent_epn), .ent_tid(ent_tid),
      .key_epn(req_epn), .key_pid(req_pid), .hit(hit)
   );

   tlb_guard_pick #(.ENTRIES(ENTRIES)) u_pick (
      .hit(hit), .any(any_hit), .idx(hit_idx)
   );

   logic             is_fetch, is_store, xlat_on;
   exc_code_e        nxt_exc;
   logic [RPN_W-1:0] nxt_ppn;

   assign is_fetch = (req_kind == ACC_FETCH);
   assign is_store = (req_kind == ACC_STORE);
   assign xlat_on  = is_fetch ? xlat_ins_en : xlat_dat_en;

   always_comb begin
      nxt_exc = EXC_NONE;
      nxt_ppn = '0;
      if (!xlat_on) begin
         nxt_ppn = RPN_W'(req_epn);
      end else if (!any_hit) begin
         nxt_exc = EXC_MISS;
      end else if (is_fetch && !ent_ex[hit_idx]) begin
         nxt_exc = EXC_FETCH;
      end else if (is_store && !ent_wr[hit_idx]) begin
         nxt_exc = EXC_DATA;
      end else begin
         nxt_ppn = ent_rpn[hit_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_ppn <= '0;
         rsp_exc <= EXC_NONE;
      end else begin
         rsp_vld <= req_vld;
         rsp_ppn <= req_vld ? nxt_ppn : '0;
         rsp_exc <= req_vld ? nxt_exc : EXC_NONE;
      end
   end
endmodule

// File: rtl/tlb_guard_chk.sv
module tlb_guard_chk
   import tlb_guard_pkg::*;
#(
   parameter int EPN_W = 20,
   parameter int RPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xlat_ins_en,
   input logic             xlat_dat_en,
   input logic             req_vld,
   input logic [EPN_W-1:0] req_epn,
   input logic [1:0]       req_kind,
   input logic             inv_all,
   input logic             rsp_vld,
   input logic [RPN_W-1:0] rsp_ppn,
   input logic [1:0]       rsp_exc
);
   logic translating;
   assign translating = (req_kind == ACC_FETCH) ? xlat_ins_en : xlat_dat_en;

   p_latency_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   p_latency_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!rsp_vld && rsp_exc == EXC_NONE && rsp_ppn == '0));
   p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !translating) |=> (rsp_exc == EXC_NONE && rsp_ppn == RPN_W'($past(req_epn))));
   p_exc_zero_ppn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc != EXC_NONE) |-> (rsp_ppn == '0));
   p_data_from_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc == EXC_DATA) |-> ($past(req_kind) == ACC_STORE));
   p_fetch_from_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc == EXC_FETCH) |-> ($past(req_kind) == ACC_FETCH));
   p_inv_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && translating && $past(inv_all)) |=> (rsp_exc == EXC_MISS));
endmodule

bind tlb_guard tlb_guard_chk #(.EPN_W(EPN_W), .RPN_W(RPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .xlat_ins_en(xlat_ins_en), .xlat_dat_en(xlat_dat_en),
   .req_vld(req_vld), .req_epn(req_epn), .req_kind(req_kind), .inv_all(inv_all),
   .rsp_vld(rsp_vld), .rsp_ppn(rsp_ppn), .rsp_exc(rsp_exc)
);

// File: tb/tlb_guard_bench.sv
module tlb_guard_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_ins_en = 1'b0, xlat_dat_en = 1'b0;
   logic        req_vld = 1'b0;
   logic [19:0] req_epn = '0;
   logic [1:0]  req_kind = '0;
   logic [7:0]  req_pid = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [19:0] wr_epn = '0, wr_rpn = '0;
   logic [7:0]  wr_tid = '0;
   logic        wr_valid = 1'b0, wr_wren = 1'b0, wr_exen = 1'b0;
   logic        inv_all = 1'b0;
   logic        rsp_vld;
   logic [19:0] rsp_ppn;
   logic [1:0]  rsp_exc;

   always #5 clk = ~clk;

   tlb_guard u_tlb_guard (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model
   bit        m_v[16], m_w[16], m_x[16];
   bit [19:0] m_e[16], m_r[16];
   bit [7:0]  m_t[16];

   function automatic void model(input bit [1:0] k, input bit [19:0] e, input bit [7:0] p,
                                 input bit ie, input bit de,
                                 output bit [1:0] xc, output bit [19:0] pp);
      bit on = (k == 2'd0) ? ie : de;
      int f = -1;
      xc = 2'd0; pp = '0;
      if (!on) begin pp = e; return; end
      for (int i = 0; i < 16; i++)
         if (f < 0 && m_v[i] && m_e[i] == e && (m_t[i] == 0 || m_t[i] == p)) f = i;
      if (f < 0) xc = 2'd1;
      else if (k == 2'd0 && !m_x[f]) xc = 2'd2;
      else if (k == 2'd2 && !m_w[f]) xc = 2'd3;
      else pp = m_r[f];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, model, check at next negedge
   task automatic step(input string tag, input bit rv, input bit [1:0] k, input bit [19:0] e,
                       input bit [7:0] p, input bit we, input bit [3:0] wi, input bit [19:0] we_e,
                       input bit [19:0] we_r, input bit [7:0] wt, input bit wv, input bit ww,
                       input bit wx, input bit inv);
      bit [1:0] xc; bit [19:0] pp;
      req_vld = rv; req_kind = k; req_epn = e; req_pid = p;
      wr_en = we; wr_idx = wi; wr_epn = we_e; wr_rpn = we_r; wr_tid = wt;
      wr_valid = wv; wr_wren = ww; wr_exen = wx; inv_all = inv;
      model(k, e, p, xlat_ins_en, xlat_dat_en, xc, pp);
      if (we) begin
         m_v[wi] = wv; m_w[wi] = ww; m_x[wi] = wx; m_e[wi] = we_e; m_r[wi] = we_r; m_t[wi] = wt;
      end
      if (inv) for (int i = 0; i < 16; i++) m_v[i] = 0;
      @(negedge clk);
      check({tag, " R2 vld"}, rsp_vld, rv);
      if (rv) begin
         check({tag, " exc"}, rsp_exc, xc);
         check({tag, " ppn"}, rsp_ppn, pp);
      end
   endtask

   task automatic look(input string tag, input bit [1:0] k, input bit [19:0] e, input bit [7:0] p);
      step(tag, 1, k, e, p, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(input bit [3:0] i, input bit [19:0] e, input bit [19:0] r, input bit [7:0] t,
                     input bit v, input bit w, input bit x);
      step("wr", 0, 0, 0, 0, 1, i, e, r, t, v, w, x, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd7);
      repeat (3) @(negedge clk);
      check("R1 vld at reset", rsp_vld, 0);
      rst_n = 1'b1;
      xlat_ins_en = 1; xlat_dat_en = 1;
      @(negedge clk);
      look("R1 fetch", 0, 20'h00010, 0);
      look("R1 store", 2, 20'h00000, 0);
      // bypass
      xlat_ins_en = 0;
      look("R3 fetch bypass", 0, 20'hABCDE, 3);
      look("R3 load still translated", 1, 20'hABCDE, 3);
      xlat_ins_en = 1; xlat_dat_en = 0;
      look("R3 store bypass", 2, 20'h12345, 3);
      xlat_dat_en = 1;
      // R8: write and lookup in the same cycle sees old contents
      step("R8 same cycle", 1, 1, 20'h00100, 5, 1, 4'd3, 20'h00100, 20'h0AAAA, 0, 1, 0, 1, 0);
      look("R8 next cycle", 1, 20'h00100, 5);
      // R5: write-enable 0
      look("R5 store denied", 2, 20'h00100, 5);
      look("R10 store still denied", 2, 20'h00100, 5);
      // R6: fetch ignores write-enable, exec 0 denies
      look("R6 fetch ok", 0, 20'h00100, 5);
      wr(4'd7, 20'h00200, 20'h0BBBB, 8'd9, 1, 1, 0);
      look("R6 fetch denied", 0, 20'h00200, 9);
      look("R5 store allowed", 2, 20'h00200, 9);
      look("R4 tag mismatch", 1, 20'h00200, 8);
      look("R10 miss stays", 1, 20'h00200, 8);
      // R7: lower index wins
      wr(4'd1, 20'h00200, 20'h0CCCC, 8'd0, 1, 0, 1);
      look("R7 low index", 1, 20'h00200, 9);
      look("R7 low index perms", 2, 20'h00200, 9);
      wr(4'd2, 20'h00300, 20'h0DDDD, 8'd0, 0, 1, 1);
      look("R4 invalid entry", 1, 20'h00300, 0);
      // R9: invalidate beats same-cycle write
      step("R9 inv", 0, 0, 0, 0, 1, 4'd4, 20'h00400, 20'h0EEEE, 0, 1, 1, 1, 1);
      look("R9 written entry gone", 1, 20'h00400, 0);
      look("R9 old entry gone", 1, 20'h00100, 5);
      // constrained random
      for (int n = 0; n < 4000; n++) begin
         bit [1:0] k = 2'($urandom_range(0, 2));
         bit [19:0] e = 20'($urandom_range(0, 7));
         bit [7:0] p = 8'($urandom_range(1, 3));
         bit rv = ($urandom_range(0, 9) != 0);
         bit we = ($urandom_range(0, 3) == 0);
         bit inv = ($urandom_range(0, 99) == 0);
         if ($urandom_range(0, 49) == 0) xlat_ins_en = ~xlat_ins_en;
         if ($urandom_range(0, 49) == 0) xlat_dat_en = ~xlat_dat_en;
         step("R4 R5 R6 R7 random", rv, k, e, p, we, 4'($urandom), 20'($urandom_range(0, 7)),
              20'($urandom), 8'($urandom_range(0, 3)), $urandom_range(0, 3) != 0,
              1'($urandom), 1'($urandom), inv);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule